// File: doc/BRIEF.md
# Three-Bus Accumulator Datapath

This block is the register and bus fabric of a small accumulator machine. It has a 14-bit program counter and a 14-bit memory address register. It has a 16-bit memory buffer register, instruction register and accumulator. Three internal buses tie them together:
- an address bus shared by the program counter, the instruction address field and the memory address register;
- a memory-side bus that carries the buffer register to the instruction register and to the second ALU operand;
- a result bus that carries the ALU output to the accumulator and the buffer register.

A separate sequencer drives one input strobe per microoperation. The datapath has no sequencing of its own.

Strobes that steer a bus act in the same cycle they are raised. Strobes that load a register act at the next rising clock edge. Two transfers can therefore share a cycle, and a register that is read onto a bus is captured elsewhere with its old value. The accumulator has one input port, fed from the result bus. A memory word reaches the accumulator through the ALU in pass-B mode. The block hands the opcode field of the instruction register and the accumulator sign bit back to the sequencer.

Top module: `accBusDatapath`

## Requirements
- R1: While `rst` is high at a rising edge, every register is cleared to zero. After that edge, with no strobes raised, `memAddr` is 0, `opCode` is 0 and `acSign` is 0.
- R2: The program counter uses the following priority at each edge: `pcClear` sets it to 0; otherwise `abusToPc` loads it from the address bus; otherwise `pcInc` adds 1, wrapping from 0x3FFF to 0.
- R3: `abusToMar` loads the address register from the address bus at the next edge. If `pcToAbus`, `abusToMar` and `pcInc` are raised together, the address register receives the program counter value from before that edge.
- R4: The address bus carries the program counter when `pcToAbus` is high, and bits 13:0 of the instruction register when `irToAbus` is high. With neither strobe high it carries 0.
- R5: `memAddr` equals the address register in the same cycle that `marToAddr` is high, and is 0 otherwise.
- R6: While `mbrToData` is high the block drives `memData` with the buffer register. Otherwise it leaves `memData` undriven. `dataToMbr` captures `memData` into the buffer register at the next edge.
- R7: `mbusToIr` loads the instruction register from the memory-side bus. That bus carries the buffer register when `mbrToMbus` is high and 0 otherwise. `opCode` is instruction register bits 15:14.
- R8: The ALU's first operand is the accumulator and its second is the memory-side bus. `aluSel` 0 gives the sum modulo 2^16, 1 passes the first operand, 2 passes the second, and 3 gives 0. `rbusToAc` and `rbusToMbr` load the result at the next edge.
- R9: `acSign` is bit 15 of the accumulator.
- R10: A register whose load strobes are all low keeps its value across an edge.
- R11: At most one of `pcToAbus` and `irToAbus` is high in a cycle, and at most one of `dataToMbr` and `rbusToMbr`. The checker flags any cycle that breaks either rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear of all registers |
| pcClear | input | 1 | Clear program counter at next edge |
| pcInc | input | 1 | Increment program counter at next edge |
| pcToAbus | input | 1 | Program counter drives address bus |
| irToAbus | input | 1 | Instruction address field drives address bus |
| abusToPc | input | 1 | Load program counter from address bus |
| abusToMar | input | 1 | Load address register from address bus |
| marToAddr | input | 1 | Address register drives memAddr |
| dataToMbr | input | 1 | Load buffer register from memData |
| mbrToData | input | 1 | Buffer register drives memData |
| mbrToMbus | input | 1 | Buffer register drives memory-side bus |
| mbusToIr | input | 1 | Load instruction register from memory-side bus |
| rbusToAc | input | 1 | Load accumulator from result bus |
| rbusToMbr | input | 1 | Load buffer register from result bus |
| aluSel | input | 2 | ALU function: 0 add, 1 pass A, 2 pass B, 3 zero |
| memAddr | output | 14 | Memory address bus |
| memData | inout | 16 | Bidirectional memory data bus |
| opCode | output | 2 | Instruction register bits 15:14 |
| acSign | output | 1 | Accumulator bit 15 |

## Verification
Two cases put two of the block's functions in the same clock edge.
- The fetch step raises increment together with the transfer of the program counter into the address register. The bench repeats it and expects the address register to trail the counter by one, including across the wrap from 0x3FFF.
- The bench captures a fresh memory word into the buffer register while the old buffer value passes through the ALU into the accumulator. It expects the accumulator to hold the old word and the buffer register the new one.

All register contents are brought out through the address and data buses, and expected values are computed as plain modular arithmetic.

// File: rtl/accBusPkg.sv
package accBusPkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 14;

  typedef enum logic [1:0] {
    ALU_ADD   = 2'd0,
    ALU_PASSA = 2'd1,
    ALU_PASSB = 2'd2,
    ALU_ZERO  = 2'd3
  } aluOpE;

  typedef struct packed {
    logic  pcClear;
    logic  pcInc;
    logic  pcToAbus;
    logic  irToAbus;
    logic  abusToPc;
    logic  abusToMar;
    logic  marToAddr;
    logic  dataToMbr;
    logic  mbrToData;
    logic  mbrToMbus;
    logic  mbusToIr;
    logic  rbusToAc;
    logic  rbusToMbr;
    aluOpE aluOp;
  } strobeT;
endpackage

// File: rtl/accAlu.sv
module accAlu
  import accBusPkg::*;
#(
  parameter int WIDTH = DATA_W
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluOpE            func,
  output logic [WIDTH-1:0] result
);
  always_comb begin
    unique case (func)
      ALU_ADD:   result = opA + opB;
      ALU_PASSA: result = opA;
      ALU_PASSB: result = opB;
      default:   result = '0;
    endcase
  end
endmodule

// File: rtl/accPcCounter.sv
module accPcCounter #(
  parameter int WIDTH = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load,
  input  logic             inc,
  input  logic [WIDTH-1:0] loadVal,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else if (load)    count <= loadVal;
    else if (inc)     count <= count + ONE;
  end
endmodule

// File: rtl/accStrobePack.sv
module accStrobePack
  import accBusPkg::*;
(
  input  logic       pcClear,
  input  logic       pcInc,
  input  logic       pcToAbus,
  input  logic       irToAbus,
  input  logic       abusToPc,
  input  logic       abusToMar,
  input  logic       marToAddr,
  input  logic       dataToMbr,
  input  logic       mbrToData,
  input  logic       mbrToMbus,
  input  logic       mbusToIr,
  input  logic       rbusToAc,
  input  logic       rbusToMbr,
  input  logic [1:0] aluSel,
  output strobeT     strb
);
  always_comb begin
    strb.pcClear   = pcClear;
    strb.pcInc     = pcInc;
    strb.pcToAbus  = pcToAbus;
    strb.irToAbus  = irToAbus;
    strb.abusToPc  = abusToPc;
    strb.abusToMar = abusToMar;
    strb.marToAddr = marToAddr;
    strb.dataToMbr = dataToMbr;
    strb.mbrToData = mbrToData;
    strb.mbrToMbus = mbrToMbus;
    strb.mbusToIr  = mbusToIr;
    strb.rbusToAc  = rbusToAc;
    strb.rbusToMbr = rbusToMbr;
    strb.aluOp     = aluOpE'(aluSel);
  end
endmodule

// File: rtl/accDatapathCore.sv
module accDatapathCore
  import accBusPkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  strobeT        strb,
  input  logic [DW-1:0] dataIn,
  output logic [DW-1:0] dataOut,
  output logic          dataOe,
  output logic [AW-1:0] addrOut,
  output logic [AW-1:0] pcQ,
  output logic [AW-1:0] marQ,
  output logic [DW-1:0] mbrQ,
  output logic [DW-1:0] irQ,
  output logic [DW-1:0] acQ
);
  logic [AW-1:0] abus;
  logic [DW-1:0] mbus;
  logic [DW-1:0] rbus;

  // Address bus: one driver at a time, PC wins if misused
  always_comb begin
    if (strb.pcToAbus)      abus = pcQ;
    else if (strb.irToAbus) abus = irQ[AW-1:0];
    else                    abus = '0;
  end

  assign mbus = strb.mbrToMbus ? mbrQ : '0;

  accAlu #(.WIDTH(DW)) uAlu (
    .opA   (acQ),
    .opB   (mbus),
    .func  (strb.aluOp),
    .result(rbus)
  );

  accPcCounter #(.WIDTH(AW)) uPc (
    .clk    (clk),
    .rst    (rst),
    .clear  (strb.pcClear),
    .load   (strb.abusToPc),
    .inc    (strb.pcInc),
    .loadVal(abus),
    .count  (pcQ)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      marQ <= '0;
      mbrQ <= '0;
      irQ  <= '0;
      acQ  <= '0;
    end else begin
      if (strb.abusToMar)      marQ <= abus;
      if (strb.dataToMbr)      mbrQ <= dataIn;
      else if (strb.rbusToMbr) mbrQ <= rbus;
      if (strb.mbusToIr)       irQ  <= mbus;
      if (strb.rbusToAc)       acQ  <= rbus;
    end
  end

  assign addrOut = strb.marToAddr ? marQ : '0;
  assign dataOut = mbrQ;
  assign dataOe  = strb.mbrToData;
endmodule

// File: rtl/accBusDatapath.sv
module accBusDatapath
  import accBusPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pcClear,
  input  logic              pcInc,
  input  logic              pcToAbus,
  input  logic              irToAbus,
  input  logic              abusToPc,
  input  logic              abusToMar,
  input  logic              marToAddr,
  input  logic              dataToMbr,
  input  logic              mbrToData,
  input  logic              mbrToMbus,
  input  logic              mbusToIr,
  input  logic              rbusToAc,
  input  logic              rbusToMbr,
  input  logic [1:0]        aluSel,
  output logic [ADDR_W-1:0] memAddr,
  inout  wire  [DATA_W-1:0] memData,
  output logic [1:0]        opCode,
  output logic              acSign
);
  strobeT            strb;
  logic [DATA_W-1:0] dataOut;
  logic              dataOe;
  logic [ADDR_W-1:0] pcQ;
  logic [ADDR_W-1:0] marQ;
  logic [DATA_W-1:0] mbrQ;
  logic [DATA_W-1:0] irQ;
  logic [DATA_W-1:0] acQ;

  accStrobePack uCtl (
    .pcClear(pcClear), .pcInc(pcInc), .pcToAbus(pcToAbus), .irToAbus(irToAbus),
    .abusToPc(abusToPc), .abusToMar(abusToMar), .marToAddr(marToAddr),
    .dataToMbr(dataToMbr), .mbrToData(mbrToData), .mbrToMbus(mbrToMbus),
    .mbusToIr(mbusToIr), .rbusToAc(rbusToAc), .rbusToMbr(rbusToMbr),
    .aluSel(aluSel), .strb(strb)
  );

  accDatapathCore #(.DW(DATA_W), .AW(ADDR_W)) uData (
    .clk(clk), .rst(rst), .strb(strb), .dataIn(memData),
    .dataOut(dataOut), .dataOe(dataOe), .addrOut(memAddr),
    .pcQ(pcQ), .marQ(marQ), .mbrQ(mbrQ), .irQ(irQ), .acQ(acQ)
  );

  assign memData = dataOe ? dataOut : 'z;
  assign opCode  = irQ[DATA_W-1 -: 2];
  assign acSign  = acQ[DATA_W-1];
endmodule

// File: rtl/accBusChecker.sv
module accBusChecker
  import accBusPkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              pcClear,
  input logic              pcInc,
  input logic              pcToAbus,
  input logic              irToAbus,
  input logic              abusToPc,
  input logic              abusToMar,
  input logic              marToAddr,
  input logic              dataToMbr,
  input logic              mbrToData,
  input logic              rbusToAc,
  input logic              rbusToMbr,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memData,
  input logic [ADDR_W-1:0] pcQ,
  input logic [ADDR_W-1:0] marQ,
  input logic [DATA_W-1:0] mbrQ,
  input logic [DATA_W-1:0] acQ
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (pcQ == '0 && marQ == '0 && mbrQ == '0 && acQ == '0));

  a_r2_clear_wins: assert property (@(posedge clk) disable iff (rst)
    pcClear |=> pcQ == '0);

  a_r3_mar_old_pc: assert property (@(posedge clk) disable iff (rst)
    (pcToAbus && !irToAbus && abusToMar && pcInc && !pcClear && !abusToPc)
      |=> (marQ == $past(pcQ) && pcQ == ADDR_W'($past(pcQ) + 1'b1)));

  a_r5_addr_idle: assert property (@(posedge clk) disable iff (rst)
    !marToAddr |-> memAddr == '0);

  a_r6_data_drive: assert property (@(posedge clk) disable iff (rst)
    (mbrToData && !dataToMbr) |-> memData == mbrQ);

  a_r10_ac_hold: assert property (@(posedge clk) disable iff (rst)
    !rbusToAc |=> acQ == $past(acQ));

  a_r11_abus_single: assert property (@(posedge clk) disable iff (rst)
    !(pcToAbus && irToAbus));

  a_r11_mbr_single: assert property (@(posedge clk) disable iff (rst)
    !(dataToMbr && rbusToMbr));
endmodule

bind accBusDatapath accBusChecker uChk (
  .clk(clk), .rst(rst), .pcClear(pcClear), .pcInc(pcInc),
  .pcToAbus(pcToAbus), .irToAbus(irToAbus), .abusToPc(abusToPc),
  .abusToMar(abusToMar), .marToAddr(marToAddr), .dataToMbr(dataToMbr),
  .mbrToData(mbrToData), .rbusToAc(rbusToAc), .rbusToMbr(rbusToMbr),
  .memAddr(memAddr), .memData(memData),
  .pcQ(pcQ), .marQ(marQ), .mbrQ(mbrQ), .acQ(acQ)
);

// File: tb/sim_accBusDatapath.sv
module sim_accBusDatapath;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 0;
  logic rst;
  logic pcClear, pcInc, pcToAbus, irToAbus, abusToPc, abusToMar, marToAddr;
  logic dataToMbr, mbrToData, mbrToMbus, mbusToIr, rbusToAc, rbusToMbr;
  logic [1:0]  aluSel;
  logic [13:0] memAddr;
  wire  [15:0] memData;
  logic [1:0]  opCode;
  logic        acSign;
  logic [15:0] tbData;
  logic        tbDrive;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  assign memData = tbDrive ? tbData : 'z;

  always #(CLK_PERIOD/2) clk = ~clk;

  accBusDatapath u0 (
    .clk(clk), .rst(rst), .pcClear(pcClear), .pcInc(pcInc),
    .pcToAbus(pcToAbus), .irToAbus(irToAbus), .abusToPc(abusToPc),
    .abusToMar(abusToMar), .marToAddr(marToAddr), .dataToMbr(dataToMbr),
    .mbrToData(mbrToData), .mbrToMbus(mbrToMbus), .mbusToIr(mbusToIr),
    .rbusToAc(rbusToAc), .rbusToMbr(rbusToMbr), .aluSel(aluSel),
    .memAddr(memAddr), .memData(memData), .opCode(opCode), .acSign(acSign)
  );

  task automatic idle();
    {pcClear, pcInc, pcToAbus, irToAbus, abusToPc, abusToMar, marToAddr} = '0;
    {dataToMbr, mbrToData, mbrToMbus, mbusToIr, rbusToAc, rbusToMbr} = '0;
    aluSel = 2'd0; tbDrive = 0; tbData = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    idle(); #1;
  endtask

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic loadMbr(logic [15:0] v);
    tbDrive = 1; tbData = v; dataToMbr = 1; tick();
  endtask

  task automatic loadAc(logic [15:0] v);
    loadMbr(v);
    mbrToMbus = 1; aluSel = 2'd2; rbusToAc = 1; tick();
  endtask

  task automatic loadIr(logic [15:0] v);
    loadMbr(v);
    mbrToMbus = 1; mbusToIr = 1; tick();
  endtask

  task automatic readMbr(output logic [15:0] v);
    mbrToData = 1; #1; v = memData; idle(); #1;
  endtask

  task automatic readAc(output logic [15:0] v);
    aluSel = 2'd1; rbusToMbr = 1; tick();
    readMbr(v);
  endtask

  task automatic readMar(output logic [13:0] v);
    marToAddr = 1; #1; v = memAddr; idle(); #1;
  endtask

  task automatic readPc(output logic [13:0] v);
    pcToAbus = 1; abusToMar = 1; tick();
    readMar(v);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [13:0] a;
    idle();
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0; #1;

    // R1 reset state
    chk("R1 memAddr idle", {2'b0, memAddr}, 16'h0);
    chk("R1 opCode", {14'b0, opCode}, 16'h0);
    chk("R1 acSign", {15'b0, acSign}, 16'h0);
    readMar(a); chk("R1 MAR zero", {2'b0, a}, 16'h0);
    readMbr(v); chk("R1 MBR zero", v, 16'h0);
    readAc(v);  chk("R1 AC zero", v, 16'h0);

    // R3 fetch steps: MAR gets old PC while PC increments
    for (int k = 0; k < 6; k++) begin
      pcToAbus = 1; abusToMar = 1; pcInc = 1; tick();
      readMar(a); chk("R3 MAR old PC", {2'b0, a}, 16'(k));
    end
    readPc(a); chk("R2 PC after incs", {2'b0, a}, 16'd6);

    // R5 address gated off while MAR nonzero
    chk("R5 memAddr zero when not gated", {2'b0, memAddr}, 16'h0);

    // R7 IR load via MBUS, opcode field
    loadIr(16'hFFFF);
    chk("R7 opCode", {14'b0, opCode}, 16'h3);
    // R4 IR address field to PC, then R2 wrap
    irToAbus = 1; abusToPc = 1; tick();
    pcToAbus = 1; abusToMar = 1; pcInc = 1; tick();
    readMar(a); chk("R4 PC loaded from IR field", {2'b0, a}, 16'h3FFF);
    readPc(a);  chk("R2 PC wrap", {2'b0, a}, 16'h0);

    // R2 priority: clear over load over inc
    loadIr(16'hD234);
    chk("R7 opCode 3", {14'b0, opCode}, 16'h3);
    irToAbus = 1; abusToPc = 1; pcInc = 1; pcClear = 1; tick();
    readPc(a); chk("R2 clear wins", {2'b0, a}, 16'h0);
    irToAbus = 1; abusToPc = 1; pcInc = 1; tick();
    readPc(a); chk("R2 load beats inc", {2'b0, a}, 16'h1234);
    irToAbus = 1; abusToMar = 1; tick();
    readMar(a); chk("R4 IR field to MAR", {2'b0, a}, 16'h1234);
    abusToMar = 1; tick();
    readMar(a); chk("R4 undriven ABUS is zero", {2'b0, a}, 16'h0);

    // R6 data bus released when not driving, driven when enabled
    loadMbr(16'hA5C3);
    tbDrive = 1; tbData = 16'h1E2F; #1;
    chk("R6 released bus reads external", memData, 16'h1E2F);
    idle(); #1;
    readMbr(v); chk("R6 MBR drives bus", v, 16'hA5C3);

    // R8 add sweep, modulo 2^16, with R9 sign
    for (int i = 0; i < 24; i++) begin
      logic [15:0] x, y, s;
      x = 16'(i * 16'h2B3D + 16'h7F00);
      y = 16'(i * 16'h9E37) ^ 16'h00FF;
      if (i == 0) begin x = 16'hFFFF; y = 16'h0001; end
      if (i == 1) begin x = 16'h7FFF; y = 16'h0001; end
      if (i == 2) begin x = 16'h8000; y = 16'h8000; end
      s = x + y;
      loadAc(x);
      loadMbr(y);
      mbrToMbus = 1; aluSel = 2'd0; rbusToAc = 1; tick();
      chk("R9 acSign", {15'b0, acSign}, {15'b0, s[15]});
      readAc(v); chk("R8 add", v, s);
    end

    // R8 pass A, second operand absent, zero function
    loadAc(16'h4321);
    loadMbr(16'h1111);
    aluSel = 2'd1; mbrToMbus = 1; rbusToAc = 1; tick();
    readAc(v); chk("R8 pass A", v, 16'h4321);
    loadMbr(16'h1111);
    aluSel = 2'd0; rbusToAc = 1; tick();
    readAc(v); chk("R8 B is zero without MBUS drive", v, 16'h4321);
    aluSel = 2'd3; rbusToAc = 1; tick();
    readAc(v); chk("R8 zero function", v, 16'h0);

    // same edge: old MBR through ALU into AC while MBR takes new data
    loadMbr(16'hBEEF);
    mbrToMbus = 1; aluSel = 2'd2; rbusToAc = 1;
    dataToMbr = 1; tbDrive = 1; tbData = 16'h0F0F; tick();
    readMbr(v); chk("R6 MBR new data", v, 16'h0F0F);
    readAc(v);  chk("R8 AC old MBR", v, 16'hBEEF);

    // R10 hold with no strobes
    loadAc(16'h9C3A);
    loadMbr(16'h5A5A);
    irToAbus = 1; abusToPc = 1; tick();
    repeat (4) tick();
    chk("R10 opCode held", {14'b0, opCode}, 16'h3);
    readMbr(v); chk("R10 MBR held", v, 16'h5A5A);
    readPc(a);  chk("R10 PC held", {2'b0, a}, 16'h1234);
    readAc(v);  chk("R10 AC held", v, 16'h9C3A);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule